// File: doc/BRIEF.md
# Edge-Counting Power Mode Controller

This block keeps track of the power state of a serial sampling converter. It watches two plain control inputs: the conversion-start strobe and the serial clock. Both are asynchronous to the system clock. The block counts rising edges of the strobe that arrive with no rising serial clock edge in between. Reaching one count threshold drops the device into a light nap state. Reaching a higher threshold drops it into a deep sleep state.

A rising serial clock edge wakes the device from either state. Waking from nap returns it to active at once. Waking from sleep passes through a settling state first, because the reference needs time to settle. That state lasts a fixed number of system clock cycles, and the ready flag stays low until it ends.

The outputs are the mode code, an enable for the conversion core, an enable for the reference, and a ready flag. All inputs and outputs are plain level signals. No data stream crosses the block's edge, so there is no valid/ready interface and no back-pressure.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode is active (`mode_o` = 2'b00), both enables are 1 and `ready_o` is 1.
- R2: When two strobe rising edges arrive with no serial clock rising edge between them, the mode changes to nap (2'b01). In nap `core_en_o` = 0, `ref_en_o` = 1 and `ready_o` = 0.
- R3: When four strobe rising edges arrive with no serial clock rising edge between them, the mode changes to sleep (2'b10). In sleep both enables are 0 and `ready_o` = 0.
- R4: A rising serial clock edge sets the strobe count back to zero. A strobe edge, then a clock edge, then a strobe edge leaves the block active. Serial clock edges while the block is active have no effect on the outputs.
- R5: A rising serial clock edge in nap returns the block directly to active with `ready_o` = 1. The block never passes through the settling state on this path.
- R6: A rising serial clock edge in sleep moves the block to settling (2'b11). In settling `core_en_o` = 1, `ref_en_o` = 1 and `ready_o` = 0. Sleep is left only toward settling.
- R7: Settling lasts exactly `SETTLE_CYCLES` system clock cycles, then the block returns to active with `ready_o` = 1.
- R8: The strobe count saturates at four. A third strobe edge in nap keeps the block in nap. Strobe edges beyond the fourth keep the block in sleep.
- R9: A single strobe edge leaves the block active. A strobe held high for many cycles counts as one edge.
- R10: In every mode, `ready_o` is 1 only in active, `core_en_o` is 0 only in nap and sleep, and `ref_en_o` is 0 only in sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_start_i | input | 1 | Conversion-start strobe, asynchronous |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| mode_o | output | 2 | 00 active, 01 nap, 10 sleep, 11 settling |
| core_en_o | output | 1 | Power enable for the conversion core |
| ref_en_o | output | 1 | Power enable for the internal reference |
| ready_o | output | 1 | High when conversions can start |

## Verification
The assertions check on every cycle the relation between the mode code and the three flags, and the transitions that each mode allows. Nap never leads into settling, and sleep is left only toward settling. A counter in the checker requires each settling run to last exactly `SETTLE_CYCLES` cycles.

Only the bench scenarios can show that edges are counted rather than levels, and that a serial clock edge between strobes restarts the count. They also show saturation beyond four edges and the path back to active after each wake-up.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    PM_ACTIVE = 2'b00,
    PM_NAP    = 2'b01,
    PM_SLEEP  = 2'b10,
    PM_SETTLE = 2'b11
  } pm_mode_e;
endpackage

// File: rtl/pmc_edge_sync.sv
// Brings an asynchronous level into the clock domain through a flop chain
// and raises a one-cycle pulse on each rising edge.
module pmc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else if (i == 0) chain_q[i] <= async_i;
        else chain_q[i] <= chain_q[(i > 0) ? i - 1 : 0];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/pmc_strobe_count.sv
// Counts strobe edges since the last serial clock edge; saturates at LIMIT.
module pmc_strobe_count #(
  parameter int LIMIT = 4,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] count_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_o <= '0;
    end else if (clr_i) begin
      count_o <= inc_i ? W'(1) : '0;
    end else if (inc_i && count_o != W'(LIMIT)) begin
      count_o <= count_o + W'(1);
    end
  end
endmodule

// File: rtl/pmc_settle_timer.sv
// One-shot down counter: done_o marks the last of CYCLES cycles after start_i.
module pmc_settle_timer #(
  parameter int CYCLES = 100000,
  localparam int W = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic done_o
);
  logic [W-1:0] remain_q;
  logic         running_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q  <= '0;
      running_q <= 1'b0;
    end else if (start_i) begin
      remain_q  <= W'(CYCLES - 1);
      running_q <= 1'b1;
    end else if (running_q) begin
      if (remain_q == '0) running_q <= 1'b0;
      else                remain_q  <= remain_q - W'(1);
    end
  end

  assign done_o = running_q && (remain_q == '0);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int NAP_EDGES     = 2,
  parameter int SLEEP_EDGES   = 4,
  parameter int SETTLE_CYCLES = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       conv_start_i,
  input  logic       ser_clk_i,
  output logic [1:0] mode_o,
  output logic       core_en_o,
  output logic       ref_en_o,
  output logic       ready_o
);
  localparam int CNT_W = $clog2(SLEEP_EDGES + 1);

  logic             conv_rise, sclk_rise;
  logic [CNT_W-1:0] strobe_cnt;
  logic             settle_start, settle_done;
  pm_mode_e         state_q, state_d;

  pmc_edge_sync #(.STAGES(SYNC_STAGES)) u_conv_sync (
    .clk(clk), .rst_n(rst_n), .async_i(conv_start_i), .rise_o(conv_rise)
  );

  pmc_edge_sync #(.STAGES(SYNC_STAGES)) u_sclk_sync (
    .clk(clk), .rst_n(rst_n), .async_i(ser_clk_i), .rise_o(sclk_rise)
  );

  pmc_strobe_count #(.LIMIT(SLEEP_EDGES)) u_count (
    .clk(clk), .rst_n(rst_n), .inc_i(conv_rise), .clr_i(sclk_rise),
    .count_o(strobe_cnt)
  );

  pmc_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst_n(rst_n), .start_i(settle_start), .done_o(settle_done)
  );

  always_comb begin
    state_d      = state_q;
    settle_start = 1'b0;
    case (state_q)
      PM_ACTIVE: begin
        if (!sclk_rise) begin
          if (strobe_cnt == CNT_W'(SLEEP_EDGES))     state_d = PM_SLEEP;
          else if (strobe_cnt >= CNT_W'(NAP_EDGES))  state_d = PM_NAP;
        end
      end
      PM_NAP: begin
        if (sclk_rise)                                state_d = PM_ACTIVE;
        else if (strobe_cnt == CNT_W'(SLEEP_EDGES))   state_d = PM_SLEEP;
      end
      PM_SLEEP: begin
        if (sclk_rise) begin
          state_d      = PM_SETTLE;
          settle_start = 1'b1;
        end
      end
      PM_SETTLE: begin
        if (settle_done) state_d = PM_ACTIVE;
      end
      default: state_d = PM_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PM_ACTIVE;
    else        state_q <= state_d;
  end

  assign mode_o    = state_q;
  assign core_en_o = (state_q == PM_ACTIVE) || (state_q == PM_SETTLE);
  assign ref_en_o  = (state_q != PM_SLEEP);
  assign ready_o   = (state_q == PM_ACTIVE);
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
  parameter int SETTLE_CYCLES = 100000
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       core_en,
  input logic       ref_en,
  input logic       ready
);
  int unsigned settle_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             settle_run <= 0;
    else if (mode == 2'b11) settle_run <= settle_run + 1;
    else                    settle_run <= 0;
  end

  assert_ready_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ready == (mode == 2'b00));

  assert_nap_ref_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> (ref_en && !core_en));

  assert_sleep_all_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |-> (!ref_en && !core_en));

  assert_nap_no_settle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |=> (mode != 2'b11));

  assert_sleep_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |=> (mode == 2'b10 || mode == 2'b11));

  assert_settle_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11) |=> (mode == 2'b11 || mode == 2'b00));

  assert_settle_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b11 && settle_run != 0) |-> (settle_run == SETTLE_CYCLES));
endmodule

bind pwr_mode_ctrl pmc_checker #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_pmc_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode_o), .core_en(core_en_o),
  .ref_en(ref_en_o), .ready(ready_o)
);

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 20;

  logic clk = 1'b0, rst_n = 1'b0, conv = 1'b0, sclk = 1'b0;
  logic [1:0] mode;
  logic core_en, ref_en, ready;
  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct {
    string      tag;
    logic [1:0] mode;
    logic       core, refe, rdy;
  } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl #(.SETTLE_CYCLES(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .conv_start_i(conv), .ser_clk_i(sclk),
    .mode_o(mode), .core_en_o(core_en), .ref_en_o(ref_en), .ready_o(ready)
  );

  // Expected flags follow R10 from the mode code.
  task automatic expect_mode(string tag, logic [1:0] m);
    exp_t e;
    @(posedge clk);
    e.tag  = tag;
    e.mode = m;
    e.core = (m == 2'b00) || (m == 2'b11);
    e.refe = (m != 2'b10);
    e.rdy  = (m == 2'b00);
    sb_q.push_back(e);
  endtask

  // Monitor: compares queued expectations at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (mode !== e.mode || core_en !== e.core || ref_en !== e.refe || ready !== e.rdy) begin
          failures++;
          $display("FAIL %s: mode/core/ref/ready actual=%b/%b/%b/%b expected=%b/%b/%b/%b",
                   e.tag, mode, core_en, ref_en, ready, e.mode, e.core, e.refe, e.rdy);
        end
      end
    end
  end

  task automatic check_val(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_conv(int hold);
    @(negedge clk) conv = 1'b1;
    repeat (hold) @(negedge clk);
    conv = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_sclk();
    @(negedge clk) sclk = 1'b1;
    repeat (2) @(negedge clk);
    sclk = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    expect_mode("R1 reset state", 2'b00);

    pulse_conv(2);
    expect_mode("R9 single strobe stays active", 2'b00);
    pulse_sclk();
    pulse_conv(30);
    expect_mode("R9 long strobe counts once", 2'b00);
    pulse_sclk();
    expect_mode("R4 clock edge while active no effect", 2'b00);

    pulse_conv(2);
    pulse_sclk();
    pulse_conv(2);
    expect_mode("R4 clock edge restarts count", 2'b00);

    pulse_conv(2);
    expect_mode("R2 two strobes enter nap", 2'b01);
    pulse_conv(2);
    expect_mode("R8 third strobe stays nap", 2'b01);
    pulse_conv(2);
    expect_mode("R3 four strobes enter sleep", 2'b10);
    pulse_conv(2);
    pulse_conv(2);
    expect_mode("R8 extra strobes stay sleep", 2'b10);

    // Wake from sleep, then measure the settling run.
    begin
      int n = 0;
      int guard = 0;
      @(negedge clk) sclk = 1'b1;
      while (mode != 2'b11 && guard < 20) begin
        @(negedge clk);
        guard++;
      end
      expect_mode("R6 sleep wakes into settling", 2'b11);
      @(negedge clk);
      sclk = 1'b0;
      n = 1;
      while (mode == 2'b11 && n < 10 * SETTLE) begin
        @(negedge clk);
        if (mode == 2'b11) n++;
      end
      check_val("R7 settling length in cycles", n + 1, SETTLE);
      expect_mode("R7 active and ready after settling", 2'b00);
    end

    pulse_conv(2);
    pulse_conv(2);
    expect_mode("R2 nap again", 2'b01);
    begin
      int guard = 0;
      bit saw_settle = 0;
      @(negedge clk) sclk = 1'b1;
      while (mode != 2'b00 && guard < 10) begin
        @(negedge clk);
        if (mode == 2'b11) saw_settle = 1;
        guard++;
      end
      check_val("R5 nap wake skips settling", saw_settle, 0);
      check_val("R5 nap wake latency within sync delay", (guard <= 4) ? 1 : 0, 1);
      expect_mode("R5 ready right after nap wake", 2'b00);
      @(negedge clk) sclk = 1'b0;
    end

    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule